// File: doc/BRIEF.md
# Refresh-Cycle Character Pattern Address Mapper

This block lets one RAM in the 8K–16K window (2000h–3FFFh) of a Z80-style bus do two jobs. During ordinary memory cycles the RAM is plain read/write storage. During the refresh half of a display fetch it becomes a character-pattern generator.

The flow of a display fetch is as follows. An M1 fetch from the upper half of memory (A15 high) delivers a display byte. If bit 6 of that byte is clear, the block latches its character code. On the refresh cycle that follows, the CPU puts its I register on A15..A8. The block then forms a window address from three parts:

- the block-select bits of I,
- the latched code,
- a 3-bit scanline row counter, which advances on horizontal sync and clears on vertical sync.

It reads the RAM at that address and presents the byte on a valid/ready stream port for the pixel shifter.

The block has two layouts:

- **Narrow layout:** 64 characters. Each even I value selects one 512-byte set.
- **Wide layout:** 128 characters. Each set is 1 KB, so I advances in steps of 4.

The layout is chosen in one of two ways. It can follow bit 0 of I, so that software switches at will. Or, when the select pin is low, it follows a fixed strap pin, and I bit 0 is then ignored.

The stream port has no back-pressure towards the bus, because a refresh cycle cannot be stretched. A byte stays valid, with stable data, until `pat_ready` is seen high. If a new pattern fetch arrives while the slot is still full, it replaces the unaccepted byte.

Top module: `cpm_pattern_mapper`

## Requirements
- R1: A memory cycle (MREQ low, RFSH high) whose A15..A13 equal 001 is a window access. It drives `ram_addr` = A12..A0. It raises `ram_we` in the same cycle when WR is low, and `cpu_rd_en` when RD is low. Outside the window, `ram_we` and `cpu_rd_en` stay low.
- R2: While RFSH is low, `ram_we` is never asserted, even if WR is low and the address is in the window.
- R3: An M1 cycle with A15 high and data bit 6 clear arms a pattern fetch and latches the code. An M1 cycle whose data bit 6 is set, or whose A15 is low, disarms it, so the next refresh yields no pattern.
- R4: In the narrow layout, the pattern address is {A12..A9 (I bits 4..1), code D5..D0, row[2:0]}. D7 has no effect.
- R5: In the wide layout, the pattern address is {A12..A10 (I bits 4..2), D7, D5..D0, row[2:0]}.
- R6: When `sel_by_ireg` is 1, the layout is wide exactly when I bit 0 (A8 in the refresh cycle) is 1. When it is 0, the layout follows `strap_wide` and I bit 0 has no effect.
- R7: The row counter advances by one on each rising edge of `hsync` and wraps from 7 to 0.
- R8: `vsync` high clears the row counter. It takes priority over an `hsync` edge in the same cycle.
- R9: On an armed refresh cycle whose A15..A13 equal 001, `ram_addr` carries the pattern address during the cycle. The RAM byte appears on `pat_data` with `pat_valid` high from the next cycle. An armed refresh outside the window produces no pattern and disarms the fetch.
- R10: `pat_valid` stays high with `pat_data` stable until a cycle with `pat_ready` high. A new pattern fetch overwrites an unaccepted byte.
- R11: After reset, `pat_valid` is low, the row counter is 0 and no fetch is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bus signals are sampled once per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | CPU address bus (I register on A15..A8 in refresh) |
| bus_din | input | 8 | CPU data bus as seen by the block |
| m1_n | input | 1 | Opcode fetch strobe, active low |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rfsh_n | input | 1 | Refresh strobe, active low |
| hsync | input | 1 | Horizontal sync; rising edge advances the row |
| vsync | input | 1 | Vertical sync; high clears the row |
| sel_by_ireg | input | 1 | 1: layout from I bit 0; 0: layout from strap |
| strap_wide | input | 1 | Fixed layout choice used when `sel_by_ireg` is 0 |
| ram_addr | output | 13 | Window RAM address |
| ram_we | output | 1 | Window RAM write enable |
| ram_wdata | output | 8 | Window RAM write data |
| ram_rdata | input | 8 | Window RAM read data |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| cpu_rd_en | output | 1 | CPU read of the window in progress |
| pat_valid | output | 1 | Pattern byte valid |
| pat_ready | input | 1 | Consumer accepts the pattern byte |
| pat_data | output | 8 | Pattern byte |

## Verification
The assertions assume that the bus strobes describe one well-formed cycle per clock. They take it that MREQ is never low with both M1 and RFSH low at once, and that RAM read data is settled within the cycle that addresses it. The stimulus keeps to this. Each bus cycle lasts exactly one clock, with inputs changed only on the falling edge. The bench memory is a combinational function of `ram_addr`, so every address has a known byte. Sync pulses are at least one cycle high and one cycle low, so each edge on `hsync` is seen exactly once.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

  // Kind of bus cycle seen in one clock
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_MEM   = 2'd1,
    CYC_FETCH = 2'd2,
    CYC_RFSH  = 2'd3
  } cyc_e;

  function automatic cyc_e classify(input logic m1_n, input logic mreq_n,
                                    input logic rfsh_n);
    cyc_e c;
    if (mreq_n)       c = CYC_IDLE;
    else if (!rfsh_n) c = CYC_RFSH;
    else if (!m1_n)   c = CYC_FETCH;
    else              c = CYC_MEM;
    return c;
  endfunction

endpackage

// File: rtl/cpm_row_counter.sv
module cpm_row_counter #(
  parameter int ROW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync,
  input  logic             vsync,
  output logic [ROW_W-1:0] row
);

  logic hs_q;
  logic hs_rise;

  assign hs_rise = hsync & ~hs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      row  <= '0;
    end else begin
      hs_q <= hsync;
      if (vsync)        row <= '0;
      else if (hs_rise) row <= row + 1'b1;
    end
  end

  // R8: frame sync clears the row
  a_r8_vsync_clears: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> (row == '0));

  // R7: line sync edge advances the row, modulo the row count
  a_r7_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_rise && !vsync) |=> (row == ROW_W'($past(row) + 1'b1)));

  // R7: without an edge the row holds
  a_r7_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_rise && !vsync) |=> $stable(row));

endmodule

// File: rtl/cpm_code_latch.sv
module cpm_code_latch
  import cpm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_e              cyc,
  input  logic              disp_area,
  input  logic [DATA_W-1:0] din,
  output logic              armed,
  output logic [CODE_W:0]   code
);

  // Bit CODE_W of the display byte marks an executable opcode
  logic is_char;
  logic take;

  assign is_char = ~din[CODE_W];
  assign take    = (cyc == CYC_FETCH) && disp_area && is_char;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      code  <= '0;
    end else begin
      if (take) code <= {din[DATA_W-1], din[CODE_W-1:0]};
      if (cyc == CYC_FETCH)     armed <= take;
      else if (cyc == CYC_RFSH) armed <= 1'b0;
    end
  end

  // R3: a character byte arms the fetch
  a_r3_arm_on_char: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc == CYC_FETCH) && disp_area && !din[CODE_W]) |=> armed);

  // R3: an opcode byte or a fetch outside the display area disarms it
  a_r3_disarm_on_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc == CYC_FETCH) && (!disp_area || din[CODE_W])) |=> !armed);

  // R9: a refresh always consumes the armed state
  a_r9_refresh_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_RFSH) |=> !armed);

endmodule

// File: rtl/cpm_addr_former.sv
module cpm_addr_former #(
  parameter int WIN_AW = 13,
  parameter int CODE_W = 6,
  parameter int ROW_W  = 3
) (
  input  logic [WIN_AW-1:CODE_W+ROW_W] blk_bits,
  input  logic [CODE_W:0]              code,
  input  logic [ROW_W-1:0]             row,
  input  logic                         wide,
  output logic [WIN_AW-1:0]            pat_addr
);

  localparam int NARROW_LO = CODE_W + ROW_W;
  localparam int WIDE_LO   = NARROW_LO + 1;

  logic [WIN_AW-1:0] narrow_addr;
  logic [WIN_AW-1:0] wide_addr;

  // 64-character sets: every block bit from I, top code bit dropped
  assign narrow_addr = {blk_bits, code[CODE_W-1:0], row};
  // 128-character sets: lowest block bit replaced by the extra code bit
  assign wide_addr   = {blk_bits[WIN_AW-1:WIDE_LO], code, row};

  assign pat_addr = wide ? wide_addr : narrow_addr;

endmodule

// File: rtl/cpm_pattern_slot.sv
module cpm_pattern_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R10: an unaccepted byte stays put
  a_r10_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load) |=> (valid && $stable(data)));

  // R10: an accepted byte without a new load leaves the slot empty
  a_r10_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !load) |=> !valid);

endmodule

// File: rtl/cpm_pattern_mapper.sv
module cpm_pattern_mapper
  import cpm_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          DATA_W  = 8,
  parameter int          WIN_AW  = 13,
  parameter int          CODE_W  = 6,
  parameter int          ROW_W   = 3,
  parameter logic [2:0]  WIN_TAG = 3'b001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              m1_n,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              rfsh_n,
  input  logic              hsync,
  input  logic              vsync,
  input  logic              sel_by_ireg,
  input  logic              strap_wide,
  output logic [WIN_AW-1:0] ram_addr,
  output logic              ram_we,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rd_en,
  output logic              pat_valid,
  input  logic              pat_ready,
  output logic [DATA_W-1:0] pat_data
);

  localparam int TAG_W  = ADDR_W - WIN_AW;
  localparam int I_BIT0 = ADDR_W - DATA_W;   // I bit 0 sits on this address line
  localparam int BLK_LO = CODE_W + ROW_W;

  cyc_e              cyc;
  logic              in_win;
  logic              disp_area;
  logic              armed;
  logic [CODE_W:0]   code;
  logic [ROW_W-1:0]  row;
  logic              wide;
  logic [WIN_AW-1:0] pat_addr;
  logic              pfetch;

  assign cyc       = classify(m1_n, mreq_n, rfsh_n);
  assign in_win    = (bus_addr[ADDR_W-1:WIN_AW] == TAG_W'(WIN_TAG));
  assign disp_area = bus_addr[ADDR_W-1];

  generate
    if (I_BIT0 >= WIN_AW) begin : g_bad_geometry
      initial $error("I bit 0 must fall inside the window address");
    end
  endgenerate

  assign wide = sel_by_ireg ? bus_addr[I_BIT0] : strap_wide;

  cpm_code_latch #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc       (cyc),
    .disp_area (disp_area),
    .din       (bus_din),
    .armed     (armed),
    .code      (code)
  );

  cpm_row_counter #(.ROW_W(ROW_W)) u_row (
    .clk   (clk),
    .rst_n (rst_n),
    .hsync (hsync),
    .vsync (vsync),
    .row   (row)
  );

  cpm_addr_former #(.WIN_AW(WIN_AW), .CODE_W(CODE_W), .ROW_W(ROW_W)) u_form (
    .blk_bits (bus_addr[WIN_AW-1:BLK_LO]),
    .code     (code),
    .row      (row),
    .wide     (wide),
    .pat_addr (pat_addr)
  );

  assign pfetch    = (cyc == CYC_RFSH) && armed && in_win;
  assign ram_addr  = pfetch ? pat_addr : bus_addr[WIN_AW-1:0];
  assign ram_we    = (cyc == CYC_MEM) && !wr_n && in_win;
  assign ram_wdata = bus_din;
  assign cpu_rd_en = ((cyc == CYC_MEM) || (cyc == CYC_FETCH)) && !rd_n && in_win;
  assign cpu_rdata = ram_rdata;

  cpm_pattern_slot #(.DATA_W(DATA_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (pfetch),
    .load_data (ram_rdata),
    .ready     (pat_ready),
    .valid     (pat_valid),
    .data      (pat_data)
  );

  // R2: refresh never writes the RAM
  a_r2_no_refresh_write: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_n |-> !ram_we);

  // R1: no write strobe outside the window
  a_r1_write_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (in_win && !wr_n && !mreq_n));

  // R9: a pattern fetch yields a valid byte on the next cycle
  a_r9_pattern_lands: assert property (@(posedge clk) disable iff (!rst_n)
    pfetch |=> (pat_valid && (pat_data == $past(ram_rdata))));

endmodule

// File: tb/tb_cpm_pattern_mapper.sv
module tb_cpm_pattern_mapper;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic [7:0]  bus_din;
  logic        m1_n, mreq_n, rd_n, wr_n, rfsh_n;
  logic        hsync, vsync, sel_by_ireg, strap_wide;
  logic [12:0] ram_addr;
  logic        ram_we;
  logic [7:0]  ram_wdata, ram_rdata, cpu_rdata, pat_data;
  logic        cpu_rd_en, pat_valid, pat_ready;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  // Bench memory: every window address holds a known byte
  function automatic logic [7:0] memb(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], a[2:0]} ^ 8'h5A;
  endfunction

  assign ram_rdata = memb(ram_addr);

  cpm_pattern_mapper dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_din(bus_din),
    .m1_n(m1_n), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n), .rfsh_n(rfsh_n),
    .hsync(hsync), .vsync(vsync), .sel_by_ireg(sel_by_ireg),
    .strap_wide(strap_wide), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .cpu_rdata(cpu_rdata),
    .cpu_rd_en(cpu_rd_en), .pat_valid(pat_valid), .pat_ready(pat_ready),
    .pat_data(pat_data)
  );

  typedef struct packed {
    logic        src_i;
    logic        strap;
    logic [7:0]  iv;
    logic [7:0]  ch;
    logic [2:0]  row;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1, 1'b0, 8'h20, 8'h00, 3'd0, 16'h2000},  // R4 first byte
    '{1'b1, 1'b0, 8'h20, 8'h20, 3'd0, 16'h2100},  // R4 scanline 8
    '{1'b1, 1'b0, 8'h36, 8'h3F, 3'd7, 16'h37FF},  // R4 scanline 191 end
    '{1'b1, 1'b0, 8'h36, 8'h20, 3'd7, 16'h3707},  // R4 scanline 191 start
    '{1'b1, 1'b0, 8'h21, 8'h85, 3'd3, 16'h222B},  // R5 D7 used
    '{1'b1, 1'b0, 8'h25, 8'h05, 3'd1, 16'h2429},  // R5
    '{1'b1, 1'b0, 8'h24, 8'h85, 3'd2, 16'h242A},  // R4 D7 ignored
    '{1'b0, 1'b0, 8'h23, 8'h11, 3'd4, 16'h228C},  // R6 strap narrow, I0 ignored
    '{1'b0, 1'b1, 8'h26, 8'h91, 3'd6, 16'h268E},  // R6 strap wide
    '{1'b1, 1'b0, 8'h3E, 8'h1A, 3'd5, 16'h3ED5},  // R4 top block
    '{1'b0, 1'b1, 8'h3C, 8'hBF, 3'd7, 16'h3FFF}   // R6 wide top byte
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    m1_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; rfsh_n = 1'b1;
    bus_addr = 16'h0000; bus_din = 8'h00;
  endtask

  task automatic hs_pulse();
    @(negedge clk) hsync = 1'b1;
    @(negedge clk) hsync = 1'b0;
  endtask

  task automatic set_row(input int n);
    @(negedge clk) vsync = 1'b1;
    @(negedge clk) vsync = 1'b0;
    for (int j = 0; j < n; j++) hs_pulse();
  endtask

  task automatic disp_fetch(input logic [15:0] a, input logic [7:0] b);
    @(negedge clk);
    idle();
    m1_n = 1'b0; mreq_n = 1'b0; rd_n = 1'b0; bus_addr = a; bus_din = b;
  endtask

  // Drives a refresh cycle; returns ram_addr seen during it
  task automatic refresh(input logic [7:0] iv, input logic wr, output logic [12:0] seen,
                         output logic we_seen);
    @(negedge clk);
    idle();
    mreq_n = 1'b0; rfsh_n = 1'b0; wr_n = wr; bus_addr = {iv, 8'h7F};
    #1 seen = ram_addr; we_seen = ram_we;
    @(negedge clk);
    idle();
    #1;
  endtask

  initial begin
    vec_t v;
    logic [12:0] seen;
    logic we_seen;
    logic [7:0] first;
    rst_n = 1'b0; hsync = 1'b0; vsync = 1'b0; pat_ready = 1'b1;
    sel_by_ireg = 1'b1; strap_wide = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11: reset state
    chk("R11 pat_valid", pat_valid, 0);
    chk("R11 ram_we", ram_we, 0);
    // R11: row 0 and nothing armed: a bare refresh gives no pattern
    refresh(8'h20, 1'b1, seen, we_seen);
    chk("R11 no armed fetch", pat_valid, 0);
    disp_fetch(16'hC000, 8'h00);
    refresh(8'h20, 1'b1, seen, we_seen);
    chk("R11 row0 addr", seen, 13'h0000);

    // Vector table: R4 R5 R6 R9
    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      sel_by_ireg = v.src_i; strap_wide = v.strap;
      set_row(int'(v.row));
      disp_fetch(16'hC000 + 16'(k), v.ch);
      refresh(v.iv, 1'b1, seen, we_seen);
      chk($sformatf("R4/R5/R6 vec%0d addr", k), seen, v.exp[12:0]);
      chk($sformatf("R9 vec%0d valid", k), pat_valid, 1);
      chk($sformatf("R9 vec%0d data", k), pat_data, memb(v.exp[12:0]));
    end
    sel_by_ireg = 1'b1; strap_wide = 1'b0;

    // R7: wrap after 9 edges -> row 1
    set_row(9);
    disp_fetch(16'hC000, 8'h00);
    refresh(8'h20, 1'b1, seen, we_seen);
    chk("R7 wrap row", seen, 13'h0001);

    // R8: vsync wins over a simultaneous hsync edge
    set_row(3);
    @(negedge clk) begin vsync = 1'b1; hsync = 1'b1; end
    @(negedge clk) begin vsync = 1'b0; hsync = 1'b0; end
    disp_fetch(16'hC000, 8'h00);
    refresh(8'h20, 1'b1, seen, we_seen);
    chk("R8 vsync priority", seen, 13'h0000);

    // R3: opcode byte (bit 6 set) -> no pattern
    disp_fetch(16'hC000, 8'h45);
    refresh(8'h20, 1'b1, seen, we_seen);
    chk("R3 opcode no pattern", pat_valid, 0);
    // R3: fetch from lower memory -> no pattern
    disp_fetch(16'h4000, 8'h05);
    refresh(8'h20, 1'b1, seen, we_seen);
    chk("R3 low fetch no pattern", pat_valid, 0);
    // R9: refresh with I outside the window -> no pattern
    disp_fetch(16'hC000, 8'h05);
    refresh(8'h40, 1'b1, seen, we_seen);
    chk("R9 outside window", pat_valid, 0);

    // R2: write strobe during refresh in window suppressed
    refresh(8'h24, 1'b0, seen, we_seen);
    chk("R2 refresh write", we_seen, 0);

    // R1: window write and read
    @(negedge clk);
    idle();
    mreq_n = 1'b0; wr_n = 1'b0; bus_addr = 16'h2345; bus_din = 8'hA7;
    #1;
    chk("R1 write strobe", ram_we, 1);
    chk("R1 write addr", ram_addr, 13'h0345);
    chk("R1 write data", ram_wdata, 8'hA7);
    @(negedge clk);
    idle();
    mreq_n = 1'b0; rd_n = 1'b0; bus_addr = 16'h3ABC;
    #1;
    chk("R1 read enable", cpu_rd_en, 1);
    chk("R1 read data", cpu_rdata, memb(13'h1ABC));
    @(negedge clk);
    idle();
    mreq_n = 1'b0; wr_n = 1'b0; rd_n = 1'b1; bus_addr = 16'h4345;
    #1;
    chk("R1 outside write", ram_we, 0);
    wr_n = 1'b1; rd_n = 1'b0;
    #1;
    chk("R1 outside read", cpu_rd_en, 0);

    // R10: hold without ready, then overwrite, then drain
    pat_ready = 1'b0;
    set_row(0);
    disp_fetch(16'hC000, 8'h01);
    refresh(8'h20, 1'b1, seen, we_seen);
    first = pat_data;
    chk("R10 first data", first, memb(13'h0008));
    repeat (2) @(negedge clk);
    #1;
    chk("R10 held valid", pat_valid, 1);
    chk("R10 held data", pat_data, memb(13'h0008));
    disp_fetch(16'hC000, 8'h02);
    refresh(8'h20, 1'b1, seen, we_seen);
    chk("R10 overwrite", pat_data, memb(13'h0010));
    @(negedge clk) pat_ready = 1'b1;
    @(negedge clk);
    #1;
    chk("R10 drained", pat_valid, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule